// File: doc/BRIEF.md
# Two-Channel Partitioned Transfer Buffer

This block holds sixteen 32-bit entries (64 bytes) in one storage array and divides them between two disk-interface channels. A configuration byte sets the division: all entries to channel 0, eight entries to each channel, or all entries to channel 1. The same byte sets a fill threshold for each channel, as a fraction of that channel's share. Each channel has its own write stream and read stream. Each channel keeps its own pointers, which wrap inside its own region of the array. Channel 1's region starts directly after channel 0's region.

Each channel drives a bus-master request when its fill level reaches its threshold. A channel can also force the request by asserting its flush input while it holds data. A channel that receives no entries reports that DMA is off for it. It accepts nothing and never requests.

After reset the configuration comes from the two channel-enable inputs. A new configuration byte is held pending while either channel holds data. It is applied in the first cycle in which both channels are empty.

Both streams use valid/ready. A write beat transfers when `in_valid` and `in_ready` are both high. The write side does not hold beats: a beat offered while `in_ready` is low is dropped and reported as an error. The read side uses first-word fall-through. `out_data` is valid whenever `out_valid` is high, and a beat leaves when `out_ready` is also high. Asserting `out_ready` while `out_valid` is low is reported as an error.

Top module: `sfifo_split`

## Requirements
- R1: While `rst_n` is low, `cfg_active` is loaded from `chan_en`, where bit 0 enables channel 0 and bit 1 enables channel 1. `chan_en`=01 gives 0x04. `chan_en`=10 gives 0x61. Any other value gives 0x2A.
- R2: `cfg_active[6:5]` sets the entries per channel. 00 gives 16 to channel 0 and 0 to channel 1. 11 gives 0 to channel 0 and 16 to channel 1. 01 or 10 gives 8 to each channel. A channel's `in_ready` is low once its count equals its share.
- R3: The threshold code is `cfg_active[3:2]` for channel 0 and `cfg_active[1:0]` for channel 1. The codes are 00 = full share, 01 = 3/4, 10 = 1/2 and 11 = 1/4. `dma_req` is high while the channel has a nonzero share and its count is greater than or equal to that level.
- R4: A channel with a zero share holds `dma_off` high, `in_ready` low, `out_valid` low and `dma_req` low. Write beats offered to it are ignored.
- R5: Each channel returns its data in the order it was accepted. Traffic on one channel never alters the data of the other channel.
- R6: A configuration write takes effect on the next edge if both channels are empty in the write cycle. Otherwise it is held pending and applied on the edge after the first cycle in which both channels are empty. A later write replaces an earlier pending value. `in_ready` is low in any cycle in which a configuration is applied, and the apply empties both pointer sets.
- R7: Bits 7 and 4 of the configuration byte are stored and shown on `cfg_active` unchanged. They have no effect on behaviour.
- R8: `dma_req` is also high while `flush` is high for that channel and its count is nonzero.
- R9: A write offered while `in_ready` is low, or a read requested while `out_valid` is low, changes no state. It raises that channel's `err_pulse` for exactly the next cycle.
- R10: An accepted write makes `out_valid` high from the next cycle. Pointers wrap inside the channel's own region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 2 | Channel enables, used only to pick the reset configuration |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration byte to write |
| cfg_active | output | 8 | Configuration byte currently applied |
| in_valid | input | 2 | Write-beat valid, one bit per channel |
| in_ready | output | 2 | Write-beat ready, one bit per channel |
| in_data | input | 64 | Write data, channel c in bits [32c+31:32c] |
| out_valid | output | 2 | Read data valid, one bit per channel |
| out_ready | input | 2 | Read accept, one bit per channel |
| out_data | output | 64 | Read data, channel c in bits [32c+31:32c] |
| flush | input | 2 | Per-channel flush request |
| dma_req | output | 2 | Per-channel bus-master request |
| dma_off | output | 2 | Per-channel DMA unavailable (zero share) |
| err_pulse | output | 2 | One-cycle refused-transfer flag per channel |

## Verification
A wrong count or a wrong share shows up at the ports on the first edge after the mistake: `in_ready` drops too early or too late, or `dma_req` toggles at the wrong level. A corrupted pointer or region base shows up as a wrong `out_data` word the next time that channel presents data. An early configuration apply changes `cfg_active` while `out_valid` is still high. A reference model of two queues is compared against every output on every cycle, so each of these faults is reported within one or two cycles of its cause.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam logic [7:0] BOOT_CH0_ONLY = 8'h04;
  localparam logic [7:0] BOOT_CH1_ONLY = 8'h61;
  localparam logic [7:0] BOOT_SHARED   = 8'h2A;

  typedef enum logic [1:0] {
    SPLIT_ALL0   = 2'b00,
    SPLIT_HALF_A = 2'b01,
    SPLIT_HALF_B = 2'b10,
    SPLIT_ALL1   = 2'b11
  } split_e;

  // reset-time configuration chosen from the channel enables
  function automatic logic [7:0] boot_cfg(input logic [1:0] en);
    case (en)
      2'b01:   return BOOT_CH0_ONLY;
      2'b10:   return BOOT_CH1_ONLY;
      default: return BOOT_SHARED;
    endcase
  endfunction

  // fill level for a threshold code: full, 3/4, 1/2, 1/4 of the share
  function automatic int level_of(input int cap, input logic [1:0] code);
    return (cap / 4) * (4 - int'(code));
  endfunction
endpackage

// File: rtl/sfifo_cfg.sv
module sfifo_cfg
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    chan_en,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          both_empty,
  output logic          apply,
  output logic [7:0]    active,
  output logic [CW-1:0] cap0,
  output logic [CW-1:0] cap1,
  output logic [CW-1:0] thr0,
  output logic [CW-1:0] thr1
);
  logic [7:0] act_q, pend_q;
  logic       pend_v;

  assign apply  = both_empty && (wr_en || pend_v);
  assign active = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= boot_cfg(chan_en);
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (apply) begin
      act_q  <= wr_en ? wr_data : pend_q;
      pend_v <= 1'b0;
    end else if (wr_en) begin
      pend_q <= wr_data;
      pend_v <= 1'b1;
    end
  end

  always_comb begin
    case (split_e'(act_q[6:5]))
      SPLIT_ALL0: begin cap0 = CW'(DEPTH);     cap1 = '0;             end
      SPLIT_ALL1: begin cap0 = '0;             cap1 = CW'(DEPTH);     end
      default:    begin cap0 = CW'(DEPTH / 2); cap1 = CW'(DEPTH / 2); end
    endcase
  end

  assign thr0 = CW'(level_of(int'(cap0), act_q[3:2]));
  assign thr1 = CW'(level_of(int'(cap1), act_q[1:0]));
endmodule

// File: rtl/sfifo_chan.sv
module sfifo_chan #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] thr,
  input  logic          restart,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  input  logic          flush,
  output logic          dma_req,
  output logic          dma_off,
  output logic          err,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic          empty
);
  logic [CW-1:0] count;
  logic [AW-1:0] wp, rp;
  logic          full, push, pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] lim);
    return (CW'(p) == lim - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == cap);
  assign empty     = (count == '0);
  assign dma_off   = (cap == '0);
  assign in_ready  = !full && !restart;
  assign out_valid = !empty;
  assign push      = in_valid && in_ready;
  assign pop       = out_ready && !empty;
  assign dma_req   = !dma_off && ((count >= thr) || (flush && !empty));
  assign wr_en     = push;
  assign wr_idx    = wp;
  assign rd_idx    = rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wp    <= '0;
      rp    <= '0;
      err   <= 1'b0;
    end else begin
      err <= (in_valid && !in_ready) || (out_ready && empty);
      if (restart) begin
        count <= '0;
        wp    <= '0;
        rp    <= '0;
      end else begin
        if (push) wp <= bump(wp, cap);
        if (pop)  rp <= bump(rp, cap);
        case ({push, pop})
          2'b10:   count <= count + CW'(1);
          2'b01:   count <= count - CW'(1);
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int NP     = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic [NP-1:0]        we,
  input  logic [NP*AW-1:0]     waddr,
  input  logic [NP*DATA_W-1:0] wdata,
  input  logic [NP*AW-1:0]     raddr,
  output logic [NP*DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (we[p]) mem[waddr[p*AW +: AW]] <= wdata[p*DATA_W +: DATA_W];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdata[p*DATA_W +: DATA_W] = mem[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/sfifo_split.sv
module sfifo_split
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          chan_en,
  input  logic                cfg_wr_en,
  input  logic [7:0]          cfg_wr_data,
  output logic [7:0]          cfg_active,
  input  logic [1:0]          in_valid,
  output logic [1:0]          in_ready,
  input  logic [2*DATA_W-1:0] in_data,
  output logic [1:0]          out_valid,
  input  logic [1:0]          out_ready,
  output logic [2*DATA_W-1:0] out_data,
  input  logic [1:0]          flush,
  output logic [1:0]          dma_req,
  output logic [1:0]          dma_off,
  output logic [1:0]          err_pulse
);
  localparam int NCH = 2;
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [CW-1:0]     cap [NCH];
  logic [CW-1:0]     thr [NCH];
  logic [AW-1:0]     widx [NCH];
  logic [AW-1:0]     ridx [NCH];
  logic [AW-1:0]     base [NCH];
  logic [NCH-1:0]    empty, we;
  logic [NCH*AW-1:0] waddr, raddr;
  logic              apply;

  sfifo_cfg #(.DEPTH(DEPTH)) cfg_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .both_empty(&empty), .apply(apply), .active(cfg_active),
    .cap0(cap[0]), .cap1(cap[1]), .thr0(thr[0]), .thr1(thr[1])
  );

  // channel 1's region begins right after channel 0's share
  assign base[0] = '0;
  assign base[1] = AW'(cap[0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sfifo_chan #(.DEPTH(DEPTH)) chan_i (
      .clk(clk), .rst_n(rst_n), .cap(cap[c]), .thr(thr[c]), .restart(apply),
      .in_valid(in_valid[c]), .in_ready(in_ready[c]),
      .out_ready(out_ready[c]), .out_valid(out_valid[c]),
      .flush(flush[c]), .dma_req(dma_req[c]), .dma_off(dma_off[c]),
      .err(err_pulse[c]), .wr_en(we[c]), .wr_idx(widx[c]), .rd_idx(ridx[c]),
      .empty(empty[c])
    );
    assign waddr[c*AW +: AW] = base[c] + widx[c];
    assign raddr[c*AW +: AW] = base[c] + ridx[c];
  end

  sfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NP(NCH)) store_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(out_data)
  );
endmodule

// File: rtl/sfifo_split_chk.sv
module sfifo_split_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          cfg_active,
  input logic [1:0]          in_valid,
  input logic [1:0]          in_ready,
  input logic [1:0]          out_valid,
  input logic [1:0]          out_ready,
  input logic [1:0]          flush,
  input logic [1:0]          dma_req,
  input logic [1:0]          dma_off,
  input logic [1:0]          err_pulse
);
  // R6: configuration cannot move while any channel holds data
  a_r6_cfg_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |=> $stable(cfg_active));

  for (genvar c = 0; c < 2; c++) begin : g_c
    a_r9_refused_push_err: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && !in_ready[c]) |=> err_pulse[c]);
    a_r9_refused_pop_err: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready[c] && !out_valid[c]) |=> err_pulse[c]);
    a_r4_zero_share_idle: assert property (@(posedge clk) disable iff (!rst_n)
      dma_off[c] |-> (!in_ready[c] && !out_valid[c] && !dma_req[c]));
    a_r8_flush_req: assert property (@(posedge clk) disable iff (!rst_n)
      (flush[c] && out_valid[c]) |-> dma_req[c]);
    a_r10_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && in_ready[c]) |=> out_valid[c]);
    a_r3_full_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[c] && !in_ready[c]) |-> dma_req[c]);
  end
endmodule

bind sfifo_split sfifo_split_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .flush(flush), .dma_req(dma_req), .dma_off(dma_off), .err_pulse(err_pulse)
);

// File: tb/sfifo_split_tb_top.sv
`timescale 1ns/1ps
module sfifo_split_tb_top;
  localparam int W = 32;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   chan_en = 2'b11;
  logic         cfg_wr_en = 1'b0;
  logic [7:0]   cfg_wr_data = '0;
  logic [7:0]   cfg_active;
  logic [1:0]   in_valid = '0, out_ready = '0, flush = '0;
  logic [1:0]   in_ready, out_valid, dma_req, dma_off, err_pulse;
  logic [2*W-1:0] in_data = '0, out_data;

  always #2.5 clk = ~clk;

  sfifo_split #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_active(cfg_active),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .flush(flush), .dma_req(dma_req), .dma_off(dma_off), .err_pulse(err_pulse)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [7:0]   m_cfg, m_pend;
  bit           m_pv;
  logic [W-1:0] mq [2][$];
  bit           m_err [2];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mcap(input int ch);
    case (m_cfg[6:5])
      2'b00:   return (ch == 0) ? D : 0;
      2'b11:   return (ch == 0) ? 0 : D;
      default: return D / 2;
    endcase
  endfunction

  function automatic int mthr(input int ch);
    int code = (ch == 0) ? int'(m_cfg[3:2]) : int'(m_cfg[1:0]);
    return (mcap(ch) / 4) * (4 - code);
  endfunction

  function automatic logic [7:0] mboot(input logic [1:0] en);
    if (en == 2'b01) return 8'h04;
    if (en == 2'b10) return 8'h61;
    return 8'h2A;
  endfunction

  task automatic compare_and_step();
    bit apply;
    bit rdy [2];
    int sz  [2];
    apply = (mq[0].size() == 0) && (mq[1].size() == 0) && (cfg_wr_en || m_pv);
    chk(cfg_active == m_cfg, "R6/R7 cfg_active", cfg_active, m_cfg);
    for (int c = 0; c < 2; c++) begin
      int cap = mcap(c);
      bit req;
      sz[c]  = mq[c].size();
      rdy[c] = (sz[c] != cap) && !apply;
      req    = (cap != 0) && ((sz[c] >= mthr(c)) || (flush[c] && sz[c] > 0));
      chk(in_ready[c] == rdy[c], "R2 in_ready", in_ready[c], rdy[c]);
      chk(out_valid[c] == (sz[c] > 0), "R10 out_valid", out_valid[c], sz[c] > 0);
      if (sz[c] > 0)
        chk(out_data[c*W +: W] == mq[c][0], "R5 out_data", out_data[c*W +: W], mq[c][0]);
      chk(dma_req[c] == req, flush[c] ? "R8 dma_req" : "R3 dma_req", dma_req[c], req);
      chk(dma_off[c] == (cap == 0), "R4 dma_off", dma_off[c], cap == 0);
      chk(err_pulse[c] == m_err[c], "R9 err_pulse", err_pulse[c], m_err[c]);
    end
    for (int c = 0; c < 2; c++) begin
      m_err[c] = (in_valid[c] && !rdy[c]) || (out_ready[c] && sz[c] == 0);
      if (out_ready[c] && sz[c] > 0) void'(mq[c].pop_front());
      if (in_valid[c] && rdy[c]) mq[c].push_back(in_data[c*W +: W]);
    end
    if (apply) begin
      m_cfg = cfg_wr_en ? cfg_wr_data : m_pend;
      m_pv  = 1'b0;
    end else if (cfg_wr_en) begin
      m_pend = cfg_wr_data;
      m_pv   = 1'b1;
    end
  endtask

  task automatic cycle(input logic [1:0] iv, input logic [1:0] ordy, input logic [1:0] fl,
                       input bit cw, input logic [7:0] cd);
    @(negedge clk);
    in_valid    = iv;
    out_ready   = ordy;
    flush       = fl;
    cfg_wr_en   = cw;
    cfg_wr_data = cd;
    in_data     = {$urandom(), $urandom()};
    #1;
    compare_and_step();
  endtask

  task automatic do_reset(input logic [1:0] en);
    @(negedge clk);
    rst_n = 1'b0; chan_en = en;
    in_valid = '0; out_ready = '0; flush = '0; cfg_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cfg = mboot(en); m_pv = 1'b0; m_pend = '0;
    mq[0].delete(); mq[1].delete();
    m_err[0] = 1'b0; m_err[1] = 1'b0;
    // R1: reset configuration from channel enables
    chk(cfg_active == mboot(en), "R1 reset cfg", cfg_active, mboot(en));
  endtask

  function automatic bit pct(input int p);
    return ($urandom_range(99) < p);
  endfunction

  task automatic run(input int n, input int pp, input int rp, input int cp, input int fp);
    for (int i = 0; i < n; i++) begin
      cycle({pct(pp), pct(pp)}, {pct(rp), pct(rp)}, {pct(fp), pct(fp)},
            pct(cp), 8'($urandom()));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] cfgs [6] = '{8'h04, 8'h61, 8'hB7, 8'h5E, 8'h0F, 8'h2A};
    do_reset(2'b11);
    run(300, 50, 50, 2, 5);
    run(200, 90, 10, 0, 5);   // fill: hits full boundaries (R2, R9)
    run(200, 10, 90, 0, 0);   // drain: empty pops (R9), pending applies (R6)
    foreach (cfgs[k]) begin
      cycle(2'b00, 2'b00, 2'b00, 1'b1, cfgs[k]);
      run(150, 70, 30, 0, 5);
      run(150, 30, 80, 3, 5);
      run(60, 0, 100, 0, 0);
    end
    do_reset(2'b01);
    run(300, 60, 40, 2, 5);   // zero share on channel 1 (R4)
    do_reset(2'b10);
    run(300, 60, 40, 2, 5);   // zero share on channel 0 (R4)
    do_reset(2'b00);
    run(200, 50, 50, 2, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule